// File: doc/BRIEF.md
# Infrared remote key code table

This block turns a decoded infrared remote frame, given as a 16-bit usercode and an 8-bit scancode, into a 16-bit key code. It also counts how many lookups in a row returned the same key. The table holds a fixed number of usercode groups. Each group has a usercode, a length and up to `MAX_KEYS` (scancode, key code) slots. Group headers and slots are written through two independent single-cycle write ports.

A lookup is a two-level sequential scan:

- The block first walks the group headers to find the lowest-numbered written group whose usercode matches the request.
- It then walks only the first `length` slots of that group, looking for the scancode.

The scan takes at most `NUM_GROUPS + MAX_KEYS + 1` cycles. When it finishes, the block pulses `lookup_done_o` for one cycle. In that cycle `hit_o`, `keycode_o` and `repeat_o` carry the new result, and they hold it until the next result.

Top module: `ir_keymap`

## Requirements
- R1: After reset `lookup_done_o`, `hit_o`, `keycode_o` and `repeat_o` are all 0, and no group matches any usercode, including 0x0000.
- R2: The lookup selects the lowest-indexed written group whose usercode equals the request. It then searches only that group, and the lowest slot index holding the scancode wins. Slots in other groups, including another group with the same usercode, are never matched.
- R3: On a hit whose key code differs from the current `keycode_o`, `hit_o` becomes 1, `keycode_o` takes the new code and `repeat_o` becomes 0.
- R4: On a hit whose key code equals the current `keycode_o`, `hit_o` becomes 1 and `repeat_o` increments by one.
- R5: `repeat_o` saturates at 2^RPT_W-1 (15 by default) and never wraps.
- R6: On a miss, either because no group matches or because the scancode is not found, `hit_o` is 0, `keycode_o` is 0 (reserved) and `repeat_o` is 0.
- R7: Each accepted request gives exactly one `lookup_done_o` pulse, one cycle wide. It comes at most `NUM_GROUPS + MAX_KEYS + 1` cycles after the accepting edge, and the outputs do not change between pulses.
- R8: `lookup_valid_i` is accepted only while no scan is running. A request raised during a scan is dropped and gives no result of its own.
- R9: Slots at or beyond a group's written length are never matched. A written length above `MAX_KEYS` is treated as `MAX_KEYS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_we_i | input | 1 | Write one group header |
| grp_sel_i | input | GRP_W (2) | Group index to write |
| grp_user_i | input | USER_W (16) | Usercode of the group |
| grp_len_i | input | KCNT_W (5) | Number of valid slots in the group |
| key_we_i | input | 1 | Write one slot |
| key_grp_i | input | GRP_W (2) | Group of the slot |
| key_idx_i | input | IDX_W (4) | Slot index within the group |
| key_scan_i | input | SCAN_W (8) | Scancode stored in the slot |
| key_code_i | input | KEY_W (16) | Key code stored in the slot |
| lookup_valid_i | input | 1 | Start a lookup (accepted only when idle) |
| lookup_user_i | input | USER_W (16) | Usercode to look up |
| lookup_scan_i | input | SCAN_W (8) | Scancode to look up |
| lookup_done_o | output | 1 | One-cycle result strobe |
| hit_o | output | 1 | Last result was a hit |
| keycode_o | output | KEY_W (16) | Last key code, 0 on a miss |
| repeat_o | output | RPT_W (4) | Consecutive same-key count |

## Verification
The assertions assume that the table is not written while a scan is running, because a header or slot changing under the scan pointer has no defined result. They also assume reset is asserted from time zero. The bench loads every group and slot before it issues any lookup, and it waits for each `lookup_done_o` before it writes or looks up again. The one exception is the deliberate mid-scan request in the R8 test. The assertion that tracks pending requests only counts a request as accepted when no scan is running and no result is due, which matches this one-outstanding-request discipline.

// File: rtl/ir_keymap_pkg.sv
package ir_keymap_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_GRP  = 2'd1,
    SCAN_KEY  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/ir_keymap_grp_tbl.sv
module ir_keymap_grp_tbl #(
  parameter int NUM_GROUPS = 4,
  parameter int MAX_KEYS   = 16,
  parameter int USER_W     = 16,
  parameter int GRP_W      = 2,
  parameter int KCNT_W     = 5
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [GRP_W-1:0]                    sel_i,
  input  logic [USER_W-1:0]                   user_i,
  input  logic [KCNT_W-1:0]                   len_i,
  output logic [NUM_GROUPS-1:0]               vld_o,
  output logic [NUM_GROUPS-1:0][USER_W-1:0]   user_o,
  output logic [NUM_GROUPS-1:0][KCNT_W-1:0]   len_o
);
  localparam logic [KCNT_W-1:0] LEN_MAX = KCNT_W'(MAX_KEYS);

  logic [KCNT_W-1:0] len_clip;
  assign len_clip = (len_i > LEN_MAX) ? LEN_MAX : len_i;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g]  <= 1'b0;
        user_o[g] <= '0;
        len_o[g]  <= '0;
      end else if (we_i && sel_i == GRP_W'(g)) begin
        vld_o[g]  <= 1'b1;
        user_o[g] <= user_i;
        len_o[g]  <= len_clip;
      end
    end
  end
endmodule

// File: rtl/ir_keymap_key_tbl.sv
module ir_keymap_key_tbl #(
  parameter int NUM_GROUPS = 4,
  parameter int MAX_KEYS   = 16,
  parameter int SCAN_W     = 8,
  parameter int KEY_W      = 16,
  parameter int GRP_W      = 2,
  parameter int IDX_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [GRP_W-1:0]  wr_grp_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [SCAN_W-1:0] wr_scan_i,
  input  logic [KEY_W-1:0]  wr_code_i,
  input  logic [GRP_W-1:0]  rd_grp_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [SCAN_W-1:0] rd_scan_o,
  output logic [KEY_W-1:0]  rd_code_o
);
  logic [SCAN_W-1:0] scan_q [NUM_GROUPS][MAX_KEYS];
  logic [KEY_W-1:0]  code_q [NUM_GROUPS][MAX_KEYS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < MAX_KEYS; k++) begin : g_key
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scan_q[g][k] <= '0;
          code_q[g][k] <= '0;
        end else if (we_i && wr_grp_i == GRP_W'(g) && wr_idx_i == IDX_W'(k)) begin
          scan_q[g][k] <= wr_scan_i;
          code_q[g][k] <= wr_code_i;
        end
      end
    end
  end

  assign rd_scan_o = scan_q[rd_grp_i][rd_idx_i];
  assign rd_code_o = code_q[rd_grp_i][rd_idx_i];
endmodule

// File: rtl/ir_keymap_scan.sv
module ir_keymap_scan
  import ir_keymap_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int USER_W     = 16,
  parameter int SCAN_W     = 8,
  parameter int KEY_W      = 16,
  parameter int GRP_W      = 2,
  parameter int IDX_W      = 4,
  parameter int KCNT_W     = 5
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               lookup_valid_i,
  input  logic [USER_W-1:0]                  lookup_user_i,
  input  logic [SCAN_W-1:0]                  lookup_scan_i,
  input  logic [NUM_GROUPS-1:0]              grp_vld_i,
  input  logic [NUM_GROUPS-1:0][USER_W-1:0]  grp_user_i,
  input  logic [NUM_GROUPS-1:0][KCNT_W-1:0]  grp_len_i,
  output logic [GRP_W-1:0]                   rd_grp_o,
  output logic [IDX_W-1:0]                   rd_idx_o,
  input  logic [SCAN_W-1:0]                  rd_scan_i,
  input  logic [KEY_W-1:0]                   rd_code_i,
  output logic                               res_valid_o,
  output logic                               res_hit_o,
  output logic [KEY_W-1:0]                   res_code_o
);
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);

  scan_state_e        state_q, state_d;
  logic [GRP_W-1:0]   gidx_q, gidx_d, sel_q, sel_d;
  logic [KCNT_W-1:0]  kidx_q, kidx_d;
  logic [USER_W-1:0]  user_q, user_d;
  logic [SCAN_W-1:0]  scan_q, scan_d;

  assign rd_grp_o = sel_q;
  assign rd_idx_o = kidx_q[IDX_W-1:0];

  always_comb begin
    state_d     = state_q;
    gidx_d      = gidx_q;
    sel_d       = sel_q;
    kidx_d      = kidx_q;
    user_d      = user_q;
    scan_d      = scan_q;
    res_valid_o = 1'b0;
    res_hit_o   = 1'b0;
    res_code_o  = '0;
    unique case (state_q)
      SCAN_IDLE: begin
        if (lookup_valid_i) begin
          state_d = SCAN_GRP;
          gidx_d  = '0;
          user_d  = lookup_user_i;
          scan_d  = lookup_scan_i;
        end
      end
      SCAN_GRP: begin
        // first matching group wins, later duplicates are unreachable
        if (grp_vld_i[gidx_q] && grp_user_i[gidx_q] == user_q) begin
          sel_d   = gidx_q;
          kidx_d  = '0;
          state_d = SCAN_KEY;
        end else if (gidx_q == LAST_GRP) begin
          res_valid_o = 1'b1;
          state_d     = SCAN_IDLE;
        end else begin
          gidx_d = gidx_q + 1'b1;
        end
      end
      SCAN_KEY: begin
        if (kidx_q >= grp_len_i[sel_q]) begin
          res_valid_o = 1'b1;
          state_d     = SCAN_IDLE;
        end else if (rd_scan_i == scan_q) begin
          res_valid_o = 1'b1;
          res_hit_o   = 1'b1;
          res_code_o  = rd_code_i;
          state_d     = SCAN_IDLE;
        end else begin
          kidx_d = kidx_q + 1'b1;
        end
      end
      default: state_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SCAN_IDLE;
      gidx_q  <= '0;
      sel_q   <= '0;
      kidx_q  <= '0;
      user_q  <= '0;
      scan_q  <= '0;
    end else begin
      state_q <= state_d;
      gidx_q  <= gidx_d;
      sel_q   <= sel_d;
      kidx_q  <= kidx_d;
      user_q  <= user_d;
      scan_q  <= scan_d;
    end
  end
endmodule

// File: rtl/ir_keymap_rpt.sv
module ir_keymap_rpt #(
  parameter int KEY_W = 16,
  parameter int RPT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic             res_hit_i,
  input  logic [KEY_W-1:0] res_code_i,
  output logic             done_o,
  output logic             hit_o,
  output logic [KEY_W-1:0] code_o,
  output logic [RPT_W-1:0] rpt_o
);
  localparam logic [RPT_W-1:0] RPT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      hit_o  <= 1'b0;
      code_o <= '0;
      rpt_o  <= '0;
    end else begin
      done_o <= res_valid_i;
      if (res_valid_i) begin
        hit_o <= res_hit_i;
        if (!res_hit_i) begin
          code_o <= '0;
          rpt_o  <= '0;
        end else if (res_code_i == code_o) begin
          rpt_o <= (rpt_o == RPT_MAX) ? rpt_o : rpt_o + 1'b1;
        end else begin
          code_o <= res_code_i;
          rpt_o  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ir_keymap.sv
module ir_keymap #(
  parameter int NUM_GROUPS = 4,
  parameter int MAX_KEYS   = 16,
  parameter int USER_W     = 16,
  parameter int SCAN_W     = 8,
  parameter int KEY_W      = 16,
  parameter int RPT_W      = 4,
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int IDX_W     = (MAX_KEYS > 1) ? $clog2(MAX_KEYS) : 1,
  localparam int KCNT_W    = $clog2(MAX_KEYS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grp_we_i,
  input  logic [GRP_W-1:0]  grp_sel_i,
  input  logic [USER_W-1:0] grp_user_i,
  input  logic [KCNT_W-1:0] grp_len_i,
  input  logic              key_we_i,
  input  logic [GRP_W-1:0]  key_grp_i,
  input  logic [IDX_W-1:0]  key_idx_i,
  input  logic [SCAN_W-1:0] key_scan_i,
  input  logic [KEY_W-1:0]  key_code_i,
  input  logic              lookup_valid_i,
  input  logic [USER_W-1:0] lookup_user_i,
  input  logic [SCAN_W-1:0] lookup_scan_i,
  output logic              lookup_done_o,
  output logic              hit_o,
  output logic [KEY_W-1:0]  keycode_o,
  output logic [RPT_W-1:0]  repeat_o
);
  logic [NUM_GROUPS-1:0]              grp_vld;
  logic [NUM_GROUPS-1:0][USER_W-1:0]  grp_user;
  logic [NUM_GROUPS-1:0][KCNT_W-1:0]  grp_len;
  logic [GRP_W-1:0]                   rd_grp;
  logic [IDX_W-1:0]                   rd_idx;
  logic [SCAN_W-1:0]                  rd_scan;
  logic [KEY_W-1:0]                   rd_code;
  logic                               res_valid, res_hit;
  logic [KEY_W-1:0]                   res_code;

  ir_keymap_grp_tbl #(
    .NUM_GROUPS(NUM_GROUPS), .MAX_KEYS(MAX_KEYS), .USER_W(USER_W),
    .GRP_W(GRP_W), .KCNT_W(KCNT_W)
  ) u_grp_tbl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(grp_we_i), .sel_i(grp_sel_i),
    .user_i(grp_user_i), .len_i(grp_len_i),
    .vld_o(grp_vld), .user_o(grp_user), .len_o(grp_len)
  );

  ir_keymap_key_tbl #(
    .NUM_GROUPS(NUM_GROUPS), .MAX_KEYS(MAX_KEYS), .SCAN_W(SCAN_W),
    .KEY_W(KEY_W), .GRP_W(GRP_W), .IDX_W(IDX_W)
  ) u_key_tbl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(key_we_i),
    .wr_grp_i(key_grp_i), .wr_idx_i(key_idx_i),
    .wr_scan_i(key_scan_i), .wr_code_i(key_code_i),
    .rd_grp_i(rd_grp), .rd_idx_i(rd_idx),
    .rd_scan_o(rd_scan), .rd_code_o(rd_code)
  );

  ir_keymap_scan #(
    .NUM_GROUPS(NUM_GROUPS), .USER_W(USER_W), .SCAN_W(SCAN_W),
    .KEY_W(KEY_W), .GRP_W(GRP_W), .IDX_W(IDX_W), .KCNT_W(KCNT_W)
  ) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lookup_valid_i(lookup_valid_i), .lookup_user_i(lookup_user_i),
    .lookup_scan_i(lookup_scan_i),
    .grp_vld_i(grp_vld), .grp_user_i(grp_user), .grp_len_i(grp_len),
    .rd_grp_o(rd_grp), .rd_idx_o(rd_idx),
    .rd_scan_i(rd_scan), .rd_code_i(rd_code),
    .res_valid_o(res_valid), .res_hit_o(res_hit), .res_code_o(res_code)
  );

  ir_keymap_rpt #(.KEY_W(KEY_W), .RPT_W(RPT_W)) u_rpt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .res_valid_i(res_valid), .res_hit_i(res_hit), .res_code_i(res_code),
    .done_o(lookup_done_o), .hit_o(hit_o), .code_o(keycode_o), .rpt_o(repeat_o)
  );
endmodule

// File: rtl/ir_keymap_chk.sv
module ir_keymap_chk #(
  parameter int NUM_GROUPS = 4,
  parameter int MAX_KEYS   = 16,
  parameter int KEY_W      = 16,
  parameter int RPT_W      = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_valid_i,
  input logic             lookup_done_o,
  input logic             hit_o,
  input logic [KEY_W-1:0] keycode_o,
  input logic [RPT_W-1:0] repeat_o
);
  localparam int LIM   = NUM_GROUPS + MAX_KEYS + 1;
  localparam int CNT_W = $clog2(LIM + 2);
  localparam logic [RPT_W-1:0] RPT_MAX = '1;

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy, accept;

  assign busy   = pend_q && !lookup_done_o;
  assign accept = lookup_valid_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (accept)             pend_q <= 1'b1;
      else if (lookup_done_o) pend_q <= 1'b0;
      if (accept)             cnt_q <= CNT_W'(1);
      else if (busy)          cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_done_o |=> !lookup_done_o);

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> cnt_q <= CNT_W'(LIM));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_done_o |-> ($stable(keycode_o) && $stable(repeat_o) && $stable(hit_o)));

  assert_no_stray_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_done_o |-> pend_q);

  assert_miss_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_done_o && !hit_o) |-> (keycode_o == '0 && repeat_o == '0));

  assert_new_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_done_o && hit_o && keycode_o != $past(keycode_o)) |-> repeat_o == '0);

  assert_same_key_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_done_o && hit_o && keycode_o == $past(keycode_o) && $past(repeat_o) != RPT_MAX)
    |-> repeat_o == $past(repeat_o) + 1'b1);

  assert_saturate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_done_o && hit_o && keycode_o == $past(keycode_o) && $past(repeat_o) == RPT_MAX)
    |-> repeat_o == RPT_MAX);
endmodule

bind ir_keymap ir_keymap_chk #(
  .NUM_GROUPS(NUM_GROUPS), .MAX_KEYS(MAX_KEYS), .KEY_W(KEY_W), .RPT_W(RPT_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .lookup_valid_i(lookup_valid_i),
  .lookup_done_o(lookup_done_o), .hit_o(hit_o), .keycode_o(keycode_o),
  .repeat_o(repeat_o)
);

// File: tb/ir_keymap_tb_top.sv
`timescale 1ns/1ps
module ir_keymap_tb_top;
  localparam int LIM = 4 + 16 + 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        grp_we_i = 1'b0;
  logic [1:0]  grp_sel_i = '0;
  logic [15:0] grp_user_i = '0;
  logic [4:0]  grp_len_i = '0;
  logic        key_we_i = 1'b0;
  logic [1:0]  key_grp_i = '0;
  logic [3:0]  key_idx_i = '0;
  logic [7:0]  key_scan_i = '0;
  logic [15:0] key_code_i = '0;
  logic        lookup_valid_i = 1'b0;
  logic [15:0] lookup_user_i = '0;
  logic [7:0]  lookup_scan_i = '0;
  logic        lookup_done_o, hit_o;
  logic [15:0] keycode_o;
  logic [3:0]  repeat_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  ir_keymap dut_i (.*);

  // {usercode, scancode, hit, keycode, repeat}
  localparam int NV = 13;
  localparam logic [44:0] VEC [NV] = '{
    {16'h00FF, 8'h12, 1'b1, 16'h0101, 4'd0},  // R3 first hit
    {16'h00FF, 8'h12, 1'b1, 16'h0101, 4'd1},  // R4
    {16'h00FF, 8'h12, 1'b1, 16'h0101, 4'd2},  // R4
    {16'h00FF, 8'h34, 1'b1, 16'h0102, 4'd0},  // R3 new key
    {16'hA55A, 8'h12, 1'b1, 16'h0201, 4'd0},  // R2 per-group scan
    {16'hA55A, 8'h77, 1'b0, 16'h0000, 4'd0},  // R9 beyond length
    {16'h00FF, 8'h99, 1'b0, 16'h0000, 4'd0},  // R2 duplicate usercode shadowed
    {16'h1234, 8'h8F, 1'b1, 16'h040F, 4'd0},  // R9 last slot of full group
    {16'h1234, 8'h80, 1'b1, 16'h0400, 4'd0},  // R2
    {16'hBEEF, 8'h12, 1'b0, 16'h0000, 4'd0},  // R6 no group
    {16'hA55A, 8'h56, 1'b1, 16'h0202, 4'd0},  // R3
    {16'hA55A, 8'h56, 1'b1, 16'h0202, 4'd1},  // R4
    {16'h00FF, 8'h34, 1'b1, 16'h0102, 4'd0}   // R3
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_grp(input logic [1:0] g, input logic [15:0] u, input logic [4:0] l);
    @(negedge clk_i);
    grp_we_i = 1'b1; grp_sel_i = g; grp_user_i = u; grp_len_i = l;
    @(negedge clk_i);
    grp_we_i = 1'b0;
  endtask

  task automatic wr_key(input logic [1:0] g, input logic [3:0] k, input logic [7:0] s,
                        input logic [15:0] c);
    @(negedge clk_i);
    key_we_i = 1'b1; key_grp_i = g; key_idx_i = k; key_scan_i = s; key_code_i = c;
    @(negedge clk_i);
    key_we_i = 1'b0;
  endtask

  task automatic lookup(input logic [15:0] u, input logic [7:0] s, output int lat);
    @(negedge clk_i);
    lookup_valid_i = 1'b1; lookup_user_i = u; lookup_scan_i = s;
    @(negedge clk_i);
    lookup_valid_i = 1'b0;
    lat = 1;
    while (!lookup_done_o && lat < 60) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic expect_res(input string req, input logic h, input logic [15:0] c,
                            input logic [3:0] r);
    check(lookup_done_o === 1'b1, {req, " done"}, 32'(lookup_done_o), 32'd1);
    check({hit_o, keycode_o, repeat_o} === {h, c, r}, req,
          32'({hit_o, keycode_o, repeat_o}), 32'({h, c, r}));
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check({lookup_done_o, hit_o, keycode_o, repeat_o} === '0, "R1 reset outputs",
          32'({lookup_done_o, hit_o, keycode_o, repeat_o}), 32'd0);
    rst_ni = 1'b1;
    // R1 unwritten groups do not match usercode 0
    lookup(16'h0000, 8'h00, lat);
    expect_res("R1 empty table miss", 1'b0, 16'h0000, 4'd0);

    // table load
    wr_grp(2'd0, 16'h00FF, 5'd3);
    wr_key(2'd0, 4'd0, 8'h12, 16'h0101);
    wr_key(2'd0, 4'd1, 8'h34, 16'h0102);
    wr_key(2'd0, 4'd2, 8'h12, 16'h0999);
    wr_grp(2'd1, 16'hA55A, 5'd2);
    wr_key(2'd1, 4'd0, 8'h12, 16'h0201);
    wr_key(2'd1, 4'd1, 8'h56, 16'h0202);
    wr_key(2'd1, 4'd2, 8'h77, 16'h0203);
    wr_grp(2'd2, 16'h00FF, 5'd1);
    wr_key(2'd2, 4'd0, 8'h99, 16'h0301);
    wr_grp(2'd3, 16'h1234, 5'd31);  // R9 clamps to 16
    for (int k = 0; k < 16; k++) wr_key(2'd3, 4'(k), 8'h80 + 8'(k), 16'h0400 + 16'(k));

    for (int v = 0; v < NV; v++) begin
      lookup(VEC[v][44:29], VEC[v][28:21], lat);
      expect_res($sformatf("R2/R3/R4/R6/R9 vector %0d", v), VEC[v][20], VEC[v][19:4],
                 VEC[v][3:0]);
      check(lat <= LIM, "R7 latency", 32'(lat), 32'(LIM));
      @(negedge clk_i);
      check(lookup_done_o === 1'b0, "R7 single pulse", 32'(lookup_done_o), 32'd0);
    end

    // R5 saturation
    lookup(16'h1234, 8'h81, lat);
    expect_res("R5 start", 1'b1, 16'h0401, 4'd0);
    for (int i = 1; i <= 18; i++) begin
      lookup(16'h1234, 8'h81, lat);
      expect_res($sformatf("R5 step %0d", i), 1'b1, 16'h0401, (i > 15) ? 4'd15 : 4'(i));
    end

    // R6 miss after saturation clears repeat
    lookup(16'h1234, 8'h7F, lat);
    expect_res("R6 scancode miss", 1'b0, 16'h0000, 4'd0);

    // R8 request during scan is dropped
    @(negedge clk_i);
    lookup_valid_i = 1'b1; lookup_user_i = 16'h1234; lookup_scan_i = 8'h8E;
    @(negedge clk_i);
    lookup_user_i = 16'hBEEF; lookup_scan_i = 8'h00;
    @(negedge clk_i);
    lookup_valid_i = 1'b0;
    lat = 0;
    while (!lookup_done_o && lat < 60) begin
      @(negedge clk_i);
      lat++;
    end
    expect_res("R8 first result", 1'b1, 16'h040E, 4'd0);
    begin
      int extra = 0;
      repeat (40) begin
        @(negedge clk_i);
        if (lookup_done_o) extra++;
      end
      check(extra == 0, "R8 no second result", 32'(extra), 32'd0);
    end
    check({hit_o, keycode_o} === {1'b1, 16'h040E}, "R8 outputs held",
          32'({hit_o, keycode_o}), 32'({1'b1, 16'h040E}));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule